// File: doc/BRIEF.md
# Stereo Audio Serial Clock and Shift Controller

This block runs entirely on the master clock of an audio serial output port. After reset it serves in one of two roles. In the clock-driving role it divides the master clock to make the bit clock and the left/right frame clock itself. In the clock-following role those two clocks come in from outside, pass through synchronizers, and have their edges detected inside the master-clock domain. The role is fixed by a strap input that is sampled while reset is held.

In both roles the block counts master-clock cycles from one rising frame-clock edge to the next, and locks onto a ratio of 256, 384 or 512. It also counts bit-clock pulses per frame to decide whether the half-frame has room for status bits. A shifter sends out one 24-bit channel word per half-frame, most significant bit first. Each new bit is placed after a falling bit-clock edge. Up to eight status bits follow the word when there is room, and zeros fill every remaining slot. The frame-clock level selects the channel, and the two words of a pair are captured together.

Top module: `sport_clkgen`

## Requirements
- R1: When driving clocks, `bclk_o` is the master clock divided by 4. It is high for exactly 2 cycles and low for exactly 2 cycles.
- R2: When driving clocks, `lrck_o` is the master clock divided by 256. It only changes in a cycle where `bclk_o` falls.
- R3: When following clocks, `bclk_o` and `lrck_o` are held at 0, and all timing comes from `bclk_i` and `lrck_i`.
- R4: `mode_master_i` is sampled only while `rst` is high. A later change of this input has no effect until the next reset.
- R5: `lock_o` rises once two successive frame measurements (master-clock cycles between rising frame edges) equal the same legal value. At that moment `ratio_sel_o` is set to 0 for 256, 1 for 384 or 2 for 512, and `err_o` is 0.
- R6: `err_o` shows whether the latest frame measurement was not 256, 384 or 512. An illegal measurement never changes `lock_o` or `ratio_sel_o`.
- R7: Once set, `lock_o` stays 1 and `ratio_sel_o` stays fixed until reset.
- R8: `stat_en_o` is 1 when the last complete frame held at least 64 rising bit-clock edges, and 0 otherwise (for example, with 48 edges per frame).
- R9: Each half-frame starts with the channel word, MSB first, with one bit per falling bit-clock edge. Next come `stat_i` MSB first if `stat_en_o` is 1, or 8 zeros if it is 0. All remaining slots are zero. Frame clock low selects the left channel. `chan_right_o` is 1 while the right word is being sent.
- R10: The right word is captured at the start of the left half. Changing `right_i` later in the frame does not alter the right half that follows.
- R11: Reset clears `sdata_o`, `lock_o`, `err_o`, `stat_en_o`, `bclk_o` and `lrck_o`, and sets `ratio_sel_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_master_i | input | 1 | Role strap: 1 drives clocks, 0 follows them |
| bclk_i | input | 1 | External bit clock (following role) |
| lrck_i | input | 1 | External frame clock (following role) |
| left_i | input | 24 | Left channel word |
| right_i | input | 24 | Right channel word |
| stat_i | input | 8 | Status bits appended after the word |
| bclk_o | output | 1 | Generated bit clock |
| lrck_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |
| chan_right_o | output | 1 | Channel currently being sent (1 = right) |
| lock_o | output | 1 | Ratio detected |
| err_o | output | 1 | Latest measurement illegal |
| ratio_sel_o | output | 2 | Detected ratio code |
| stat_en_o | output | 1 | Status slots available |

## Verification
The bench uses the default parameters: a 24-bit word, 8 status bits, a divide-by-4 bit clock, a divide-by-256 frame clock, and a 10-bit period counter sized for ratios up to 512. With these values the generated half-frame holds exactly 32 slots, so every word and status bit can be checked. In the following role the bench can also reach 384 and 512 ratios, a 48-edge frame that removes the status slots, and a 300-cycle frame that the detector must reject. An illegal frame applied after lock shows that the lock and the ratio code stay put.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    RATIO_256  = 2'd0,
    RATIO_384  = 2'd1,
    RATIO_512  = 2'd2,
    RATIO_NONE = 2'd3
  } ratio_e;

  function automatic ratio_e classify(input int unsigned m);
    case (m)
      256:     return RATIO_256;
      384:     return RATIO_384;
      512:     return RATIO_512;
      default: return RATIO_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sport_ratio_det.sv
module sport_ratio_det
  import sport_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int BCNT_W   = 8,
  parameter int MIN_BCLK = 64
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   lr_rise,
  input  logic   b_rise,
  output logic   lock_o,
  output logic   err_o,
  output ratio_e sel_o,
  output logic   stat_en_o
);
  localparam logic [BCNT_W-1:0] MIN_B = BCNT_W'(MIN_BCLK);

  logic [CNT_W-1:0]  cnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [CNT_W:0]    meas;
  logic              seen_q, prev_ok_q, lock_q, err_q, sten_q;
  ratio_e            prev_code_q, sel_q, code;

  assign meas = {1'b0, cnt_q} + 1'b1;
  always_comb code = classify(32'(meas));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      bcnt_q      <= '0;
      seen_q      <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= RATIO_NONE;
      lock_q      <= 1'b0;
      err_q       <= 1'b0;
      sten_q      <= 1'b0;
      sel_q       <= RATIO_256;
    end else if (lr_rise) begin
      cnt_q  <= '0;
      bcnt_q <= BCNT_W'(b_rise);
      seen_q <= 1'b1;
      if (seen_q) begin
        err_q       <= (code == RATIO_NONE);
        sten_q      <= (bcnt_q >= MIN_B);
        prev_ok_q   <= (code != RATIO_NONE);
        prev_code_q <= code;
        if (!lock_q && code != RATIO_NONE && prev_ok_q && prev_code_q == code) begin
          lock_q <= 1'b1;
          sel_q  <= code;
        end
      end
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (b_rise && bcnt_q != '1) bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign lock_o    = lock_q;
  assign err_o     = err_q;
  assign sel_o     = sel_q;
  assign stat_en_o = sten_q;
endmodule

// File: rtl/sport_shift.sv
module sport_shift #(
  parameter int WORD_W = 24,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_edge,
  input  logic              lr_level,
  input  logic              b_fall,
  input  logic              stat_en,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              sdata_o
);
  localparam int SH_W = WORD_W + STAT_W;

  logic [SH_W-1:0]   sh_q, load;
  logic [WORD_W-1:0] rhold_q, word;
  logic              sdata_q;

  always_comb begin
    word = lr_level ? rhold_q : left_i;
    load = {word, (stat_en ? stat_i : {STAT_W{1'b0}})};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      rhold_q <= '0;
      sdata_q <= 1'b0;
    end else if (lr_edge) begin
      if (!lr_level) rhold_q <= right_i;
      sdata_q <= load[SH_W-1];
      sh_q    <= {load[SH_W-2:0], 1'b0};
    end else if (b_fall) begin
      sdata_q <= sh_q[SH_W-1];
      sh_q    <= {sh_q[SH_W-2:0], 1'b0};
    end
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/sport_clkgen.sv
module sport_clkgen
  import sport_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int STAT_W    = 8,
  parameter int BCLK_DIV  = 4,
  parameter int FRAME_DIV = 256,
  parameter int MAX_RATIO = 512,
  parameter int MIN_BCLK  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_master_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              chan_right_o,
  output logic              lock_o,
  output logic              err_o,
  output logic [1:0]        ratio_sel_o,
  output logic              stat_en_o
);
  localparam int DIV_W  = $clog2(FRAME_DIV);
  localparam int BSEL   = $clog2(BCLK_DIV) - 1;
  localparam int CNT_W  = $clog2(MAX_RATIO) + 1;
  localparam int BCNT_W = $clog2(MAX_RATIO) - 1;

  logic             master_q;
  logic [DIV_W-1:0] mdiv_q;
  logic [1:0]       sync_q;
  logic             bclk_eff, lr_eff, bclk_prev_q, lr_prev_q;
  logic             b_rise, b_fall, lr_rise, lr_edge;
  ratio_e           sel;

  // role strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= mode_master_i;
      mdiv_q   <= '0;
    end else if (master_q) begin
      mdiv_q <= mdiv_q + 1'b1;
    end
  end

  sport_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bclk_i, lrck_i}),
    .q_o (sync_q)
  );

  assign bclk_eff = master_q ? mdiv_q[BSEL]    : sync_q[1];
  assign lr_eff   = master_q ? mdiv_q[DIV_W-1] : sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_prev_q <= 1'b0;
      lr_prev_q   <= 1'b0;
    end else begin
      bclk_prev_q <= bclk_eff;
      lr_prev_q   <= lr_eff;
    end
  end

  assign b_rise  =  bclk_eff & ~bclk_prev_q;
  assign b_fall  = ~bclk_eff &  bclk_prev_q;
  assign lr_rise =  lr_eff   & ~lr_prev_q;
  assign lr_edge =  lr_eff   ^  lr_prev_q;

  sport_ratio_det #(
    .CNT_W    (CNT_W),
    .BCNT_W   (BCNT_W),
    .MIN_BCLK (MIN_BCLK)
  ) u_det (
    .clk       (clk),
    .rst       (rst),
    .lr_rise   (lr_rise),
    .b_rise    (b_rise),
    .lock_o    (lock_o),
    .err_o     (err_o),
    .sel_o     (sel),
    .stat_en_o (stat_en_o)
  );

  sport_shift #(
    .WORD_W (WORD_W),
    .STAT_W (STAT_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .lr_edge  (lr_edge),
    .lr_level (lr_eff),
    .b_fall   (b_fall),
    .stat_en  (stat_en_o),
    .left_i   (left_i),
    .right_i  (right_i),
    .stat_i   (stat_i),
    .sdata_o  (sdata_o)
  );

  assign ratio_sel_o  = sel;
  assign bclk_o       = mdiv_q[BSEL];
  assign lrck_o       = mdiv_q[DIV_W-1];
  assign chan_right_o = lr_prev_q;
endmodule

// File: rtl/sport_clkgen_chk.sv
module sport_clkgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       master_q,
  input logic       bclk_o,
  input logic       lrck_o,
  input logic       lock_o,
  input logic       err_o,
  input logic [1:0] ratio_sel_o
);
  assert_bclk_high_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk_o) |=> bclk_o ##1 !bclk_o);

  assert_bclk_low_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk_o) |=> !bclk_o ##1 bclk_o);

  assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $fell(bclk_o));

  assert_quiet_follow_R3: assert property (@(posedge clk) disable iff (rst)
    !master_q |-> (!bclk_o && !lrck_o));

  assert_lock_clean_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (!err_o && ratio_sel_o != 2'b11));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> (lock_o && $stable(ratio_sel_o)));
endmodule

bind sport_clkgen sport_clkgen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_q    (master_q),
  .bclk_o      (bclk_o),
  .lrck_o      (lrck_o),
  .lock_o      (lock_o),
  .err_o       (err_o),
  .ratio_sel_o (ratio_sel_o)
);

// File: tb/sim_sport_clkgen.sv
module sim_sport_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_i = 1'b1;
  logic        bclk_i = 1'b0, lrck_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic [7:0]  stat_i = '0;
  logic        bclk_o, lrck_o, sdata_o, chan_right_o, lock_o, err_o, stat_en_o;
  logic [1:0]  ratio_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] lcap, rcap;
  int chan_bad, quiet_bad;

  always #2.5 clk = ~clk;

  sport_clkgen u0 (
    .clk (clk), .rst (rst), .mode_master_i (mode_i),
    .bclk_i (bclk_i), .lrck_i (lrck_i),
    .left_i (left_i), .right_i (right_i), .stat_i (stat_i),
    .bclk_o (bclk_o), .lrck_o (lrck_o), .sdata_o (sdata_o),
    .chan_right_o (chan_right_o), .lock_o (lock_o), .err_o (err_o),
    .ratio_sel_o (ratio_sel_o), .stat_en_o (stat_en_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expv(input logic [23:0] w, input logic [7:0] s,
                                       input bit sten, input int nb);
    logic [31:0] slots;
    logic [63:0] r;
    slots = {w, (sten ? s : 8'h00)};
    r = '0;
    for (int i = 0; i < nb; i++) r[63-i] = (i < 32) ? slots[31-i] : 1'b0;
    return r;
  endfunction

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1'b1; mode_i = m; bclk_i = 1'b0; lrck_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // following-role stimulus; captures the last frame when cap is set
  task automatic drive(input int ratio, input int bper, input int nfr, input bit cap);
    int half = ratio / 2;
    lcap = '0; rcap = '0; chan_bad = 0; quiet_bad = 0;
    for (int f = 0; f < nfr; f++) begin
      for (int c = 0; c < ratio; c++) begin
        @(negedge clk);
        if (bclk_o || lrck_o) quiet_bad++;
        if (cap && f == nfr - 1 && (c % bper) == bper - 1) begin
          if (c < half) begin
            lcap[63 - c / bper] = sdata_o;
            if (chan_right_o) chan_bad++;
          end else begin
            rcap[63 - (c - half) / bper] = sdata_o;
            if (!chan_right_o) chan_bad++;
          end
        end
        bclk_i = ((c % bper) >= bper / 2);
        lrck_i = (c >= half);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    chk(sdata_o == 0 && lock_o == 0 && err_o == 0 && stat_en_o == 0, "R11 flags",
        {sdata_o, lock_o, err_o, stat_en_o}, 0);
    chk(bclk_o == 0 && lrck_o == 0 && ratio_sel_o == 0, "R11 clocks/sel",
        {bclk_o, lrck_o, ratio_sel_o}, 0);
  endtask

  task automatic t_master_clocks;
    int br = 0, lr = 0, bad = 0;
    logic pb = 1'b0, pl = 1'b0;
    for (int j = 0; j < 1024; j++) begin
      @(negedge clk);
      if (bclk_o && !pb) br++;
      if (lrck_o && !pl) lr++;
      if (lrck_o != pl && !(pb && !bclk_o)) bad++;
      pb = bclk_o; pl = lrck_o;
    end
    chk(br == 256, "R1 bit clock rises", br, 256);
    chk(lr == 4, "R2 frame clock rises", lr, 4);
    chk(bad == 0, "R2 frame edge on bit fall", bad, 0);
    chk(lock_o && !err_o && ratio_sel_o == 0, "R5 driving role lock 256",
        {lock_o, err_o, ratio_sel_o}, 4'b1000);
    chk(stat_en_o == 1, "R8 64 edges per frame", stat_en_o, 1);
    // R4: strap change without reset is ignored
    mode_i = 1'b0;
    br = 0;
    for (int j = 0; j < 64; j++) begin
      @(negedge clk);
      if (bclk_o && !pb) br++;
      pb = bclk_o;
    end
    chk(br == 16, "R4 strap ignored after reset", br, 16);
    mode_i = 1'b1;
  endtask

  task automatic t_master_data;
    int li = 0, ri = 0;
    logic pb, pl;
    left_i = 24'hA5C31E; right_i = 24'h5A0F96; stat_i = 8'hC3;
    lcap = '0; rcap = '0; chan_bad = 0;
    pl = lrck_o; pb = bclk_o;
    forever begin
      @(negedge clk);
      if (pl && !lrck_o) break;
      pl = lrck_o;
    end
    pb = bclk_o;
    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      if (j == 64) right_i = 24'h123456;
      if (bclk_o && !pb) begin
        if (!lrck_o) begin
          lcap[63 - li] = sdata_o; li++;
          if (chan_right_o) chan_bad++;
        end else begin
          rcap[63 - ri] = sdata_o; ri++;
          if (!chan_right_o) chan_bad++;
        end
      end
      pb = bclk_o;
    end
    chk(lcap == expv(24'hA5C31E, 8'hC3, 1, 32), "R9 driving left word+status", lcap,
        expv(24'hA5C31E, 8'hC3, 1, 32));
    chk(rcap == expv(24'h5A0F96, 8'hC3, 1, 32), "R10 right word held from frame start", rcap,
        expv(24'h5A0F96, 8'hC3, 1, 32));
    chk(chan_bad == 0, "R9 channel indicator", chan_bad, 0);
  endtask

  task automatic t_slave_384;
    do_reset(1'b0);
    drive(384, 6, 4, 0);
    chk(lock_o && !err_o && ratio_sel_o == 1, "R5 lock 384",
        {lock_o, err_o, ratio_sel_o}, 4'b1001);
    chk(quiet_bad == 0, "R3 outputs quiet when following", quiet_bad, 0);
    chk(stat_en_o == 1, "R8 64x following", stat_en_o, 1);
  endtask

  task automatic t_slave_512_data;
    do_reset(1'b0);
    left_i = 24'h80_0001; right_i = 24'h7F_FFFE; stat_i = 8'h5A;
    drive(512, 8, 5, 1);
    chk(lock_o && ratio_sel_o == 2, "R5 lock 512", {lock_o, ratio_sel_o}, 3'b110);
    chk(lcap == expv(24'h800001, 8'h5A, 1, 32), "R9 following left", lcap,
        expv(24'h800001, 8'h5A, 1, 32));
    chk(rcap == expv(24'h7FFFFE, 8'h5A, 1, 32), "R9 following right", rcap,
        expv(24'h7FFFFE, 8'h5A, 1, 32));
    chk(chan_bad == 0, "R9 channel indicator following", chan_bad, 0);
    // illegal period after lock
    drive(300, 6, 3, 0);
    chk(err_o == 1, "R6 error on 300", err_o, 1);
    chk(lock_o && ratio_sel_o == 2, "R7 lock and code kept", {lock_o, ratio_sel_o}, 3'b110);
  endtask

  task automatic t_slave_48x;
    do_reset(1'b0);
    left_i = 24'hF0F00F; right_i = 24'h0FF0F0; stat_i = 8'hFF;
    drive(384, 8, 5, 1);
    chk(stat_en_o == 0, "R8 48 edges per frame", stat_en_o, 0);
    chk(lock_o && ratio_sel_o == 1, "R5 lock 384 at 48x", {lock_o, ratio_sel_o}, 3'b101);
    chk(lcap == expv(24'hF0F00F, 8'hFF, 0, 24), "R9 48x left word only", lcap,
        expv(24'hF0F00F, 8'hFF, 0, 24));
    chk(rcap == expv(24'h0FF0F0, 8'hFF, 0, 24), "R9 48x right word only", rcap,
        expv(24'h0FF0F0, 8'hFF, 0, 24));
  endtask

  task automatic t_illegal_only;
    do_reset(1'b0);
    drive(300, 6, 4, 0);
    chk(!lock_o && err_o && ratio_sel_o == 0, "R6 no lock on 300",
        {lock_o, err_o, ratio_sel_o}, 4'b0100);
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_master_clocks();
    t_master_data();
    t_slave_384();
    t_slave_512_data();
    t_slave_48x();
    t_illegal_only();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule